// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the converter-side control logic of the serial port on a delta-sigma analog-to-digital converter. A host clocks 8-bit commands into `sdi` on rising edges of `sclk`, most significant bit first. The block decodes each byte and runs the matching action. An action can start one conversion or a continuous train of conversions, shift a 24-bit register out on `sdo`, or take 24 bits in to write a register. All logic runs on the master clock `clk`. `sclk` is brought into that domain with a two-flop synchroniser and an edge detector.

A bit in the configuration word switches the role of `sdo`. When the bit is clear, a finished conversion sets a done bit that the host polls by reading the configuration word. When the bit is set, `sdo` itself is a completion flag: it idles high and falls when a result is ready. An all-zero command byte then clears the flag and streams the result out, and the port accepts no command until all 24 bits have left. A small conversion engine stands in for the filter. It counts `CONV_CYCLES` master clocks per conversion and captures `sample_in` as the result. There is no handshake at the edge of the block: the host paces every transfer through `sclk`, and the block applies no back-pressure.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset, the configuration word reads 0, so the port-flag bit (bit 0) and the done bit (bit 3) are both 0. `sdo` is low, the gain register reads 0x400000 and the offset register reads 0.
- R2: A command is 8 bits sampled on `sclk` rising edges, MSB first. For a read command (0x92 configuration, 0x93 gain, 0x91 offset, 0x96 conversion data), `sdo` presents the register MSB after the 8th falling edge and 23 more bits on the following falling edges. Write commands (0x82 configuration, 0x83 gain, 0x81 offset) take the next 24 bits MSB first. A configuration write changes only bit 0.
- R3: Command 0xC0 starts one conversion. With the port-flag bit at 0, its completion sets the done bit, and reading the conversion data returns the `sample_in` value captured at completion.
- R4: Reading the conversion data, gain or offset register clears the done bit. Reading the configuration word leaves it unchanged.
- R5: A 0xC0 received while a conversion is in progress abandons that conversion. Completion then comes `CONV_CYCLES` clocks after the latest 0xC0.
- R6: With the port-flag bit at 1, `sdo` is high in command mode while no result is pending and falls when a conversion completes. The done bit is not set.
- R7: With the port-flag bit at 1 and a result pending, an all-zero byte clears the flag and shifts the 24-bit result out MSB first. The port then returns to command mode with `sdo` high.
- R8: With the port-flag bit at 1, byte 0x96 is ignored: no readout starts and the pending flag stays low.
- R9: During a readout, `sdi` is ignored. Bits clocked in then do not start a command.
- R10: Command 0xA0 starts continuous conversions. An unread result is replaced by the next one, and with the port-flag bit at 1, `sdo` goes high for exactly one master clock before falling for the new result.
- R11: Any accepted non-zero command other than 0xA0 or 0xC0 ends continuous mode. The conversion in progress still completes, and no further conversion follows.
- R12: A byte that is not a recognised command is ignored, and the port stays in command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, asynchronous to `clk` |
| sdi | input | 1 | Serial command and write data, sampled on `sclk` rise |
| sample_in | input | DATA_W | Value the conversion engine captures at the end of each conversion |
| sdo | output | 1 | Serial read data, or the completion flag when the port-flag bit is 1 |

## Verification
The hardest state to reach from the ports is the one-clock high gap on `sdo` in continuous flag mode. It shows only when a result is left unread for a whole conversion period, with no `sclk` activity in that window. The stimulus enables the flag mode and starts continuous conversions. It waits for the first fall, changes `sample_in`, and then stays idle while a per-clock monitor measures the length of the high pulse. A later fetch must return the new sample, which shows that the unread result was replaced.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int CMD_BITS = 8;

  localparam logic [CMD_BITS-1:0] CMD_NULL    = 8'h00;
  localparam logic [CMD_BITS-1:0] CMD_SINGLE  = 8'hC0;
  localparam logic [CMD_BITS-1:0] CMD_CONT    = 8'hA0;
  localparam logic [CMD_BITS-1:0] CMD_RD_DATA = 8'h96;
  localparam logic [CMD_BITS-1:0] CMD_RD_CFG  = 8'h92;
  localparam logic [CMD_BITS-1:0] CMD_RD_GAIN = 8'h93;
  localparam logic [CMD_BITS-1:0] CMD_RD_OFS  = 8'h91;
  localparam logic [CMD_BITS-1:0] CMD_WR_CFG  = 8'h82;
  localparam logic [CMD_BITS-1:0] CMD_WR_GAIN = 8'h83;
  localparam logic [CMD_BITS-1:0] CMD_WR_OFS  = 8'h81;

  // bit positions inside the configuration word
  localparam int PF_BIT = 0;
  localparam int DF_BIT = 3;

  typedef enum logic [1:0] {PS_CMD, PS_WRITE, PS_READ} port_st_t;

  typedef enum logic [3:0] {
    OP_IGNORE, OP_FETCH, OP_SINGLE, OP_CONT,
    OP_RD_DATA, OP_RD_CFG, OP_RD_GAIN, OP_RD_OFS,
    OP_WR_CFG, OP_WR_GAIN, OP_WR_OFS
  } op_t;

  typedef enum logic [1:0] {WS_CFG, WS_GAIN, WS_OFS} wsel_t;
endpackage

// File: rtl/adc_sclk_edge.sv
module adc_sclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sclk_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], sclk_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_port_pkg::*;
(
  input  logic [CMD_BITS-1:0] code_i,
  input  logic                pf_i,
  input  logic                flag_i,
  output op_t                 op_o
);
  always_comb begin
    op_o = OP_IGNORE;
    case (code_i)
      CMD_NULL:    op_o = (pf_i && flag_i) ? OP_FETCH : OP_IGNORE;
      CMD_SINGLE:  op_o = OP_SINGLE;
      CMD_CONT:    op_o = OP_CONT;
      CMD_RD_DATA: op_o = pf_i ? OP_IGNORE : OP_RD_DATA;
      CMD_RD_CFG:  op_o = OP_RD_CFG;
      CMD_RD_GAIN: op_o = OP_RD_GAIN;
      CMD_RD_OFS:  op_o = OP_RD_OFS;
      CMD_WR_CFG:  op_o = OP_WR_CFG;
      CMD_WR_GAIN: op_o = OP_WR_GAIN;
      CMD_WR_OFS:  op_o = OP_WR_OFS;
      default:     op_o = OP_IGNORE;
    endcase
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int DATA_W      = 24,
  parameter int CONV_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_single_i,
  input  logic              start_cont_i,
  input  logic              stop_cont_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              done_o,
  output logic              pre_done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CW = $clog2(CONV_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] PRE  = CW'(CONV_CYCLES - 2);

  logic [CW-1:0] cnt_q;
  logic          busy_q, cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      cont_q     <= 1'b0;
      done_o     <= 1'b0;
      pre_done_o <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o     <= 1'b0;
      pre_done_o <= 1'b0;
      if (start_single_i || start_cont_i) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
        cont_q <= start_cont_i;
      end else begin
        if (stop_cont_i) cont_q <= 1'b0;
        if (busy_q) begin
          pre_done_o <= (cnt_q == PRE);
          if (cnt_q == LAST) begin
            done_o   <= 1'b1;
            result_o <= sample_i;
            cnt_q    <= '0;
            busy_q   <= cont_q && !stop_cont_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import adc_port_pkg::*;
#(
  parameter int          DATA_W      = 24,
  parameter int          CONV_CYCLES = 4096,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned GAIN_RST    = 32'h0040_0000,
  parameter int unsigned OFS_RST     = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo
);
  localparam int CMD_W = CMD_BITS;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_END = CNT_W'(DATA_W - 1);

  logic              sclk_rise, sclk_fall;
  port_st_t          st;
  wsel_t             wsel;
  logic [CNT_W-1:0]  bitcnt;
  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  code;
  logic [DATA_W-1:0] sh, data_q, gain_q, ofs_q, cfg_word, wr_word, eng_res;
  logic              pf, df, flag_pend, sdo_q;
  op_t               op;
  logic              fire, start_single, start_cont, stop_cont, rd_clr, flag_clr;
  logic              eng_done, eng_pre;

  adc_sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  assign code = {cmd_sr, sdi};

  adc_cmd_decode u_dec (
    .code_i(code), .pf_i(pf), .flag_i(flag_pend), .op_o(op)
  );

  assign fire         = sclk_rise && (st == PS_CMD) && (bitcnt == CMD_END);
  assign start_single = fire && (op == OP_SINGLE);
  assign start_cont   = fire && (op == OP_CONT);
  assign stop_cont    = fire && !(op inside {OP_IGNORE, OP_FETCH, OP_SINGLE, OP_CONT});
  assign rd_clr       = fire && (op inside {OP_RD_DATA, OP_RD_GAIN, OP_RD_OFS});
  assign flag_clr     = fire && (op inside {OP_FETCH, OP_SINGLE, OP_CONT});

  adc_conv_stub #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_single_i(start_single), .start_cont_i(start_cont),
    .stop_cont_i(stop_cont), .sample_i(sample_in),
    .done_o(eng_done), .pre_done_o(eng_pre), .result_o(eng_res)
  );

  always_comb begin
    cfg_word         = '0;
    cfg_word[PF_BIT] = pf;
    cfg_word[DF_BIT] = df;
  end

  assign wr_word = {sh[DATA_W-2:0], sdi};

  // completion bookkeeping: set wins over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df        <= 1'b0;
      flag_pend <= 1'b0;
      data_q    <= '0;
    end else begin
      if (rd_clr) df <= 1'b0;
      if (eng_pre || flag_clr) flag_pend <= 1'b0;
      if (eng_done) begin
        data_q <= eng_res;
        if (pf) flag_pend <= 1'b1;
        else    df        <= 1'b1;
      end
    end
  end

  // command / data mode sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PS_CMD;
      wsel   <= WS_CFG;
      bitcnt <= '0;
      cmd_sr <= '0;
      sh     <= '0;
      pf     <= 1'b0;
      gain_q <= DATA_W'(GAIN_RST);
      ofs_q  <= DATA_W'(OFS_RST);
    end else begin
      case (st)
        PS_CMD: begin
          if (sclk_rise) begin
            cmd_sr <= code[CMD_W-2:0];
            if (bitcnt == CMD_END) begin
              bitcnt <= '0;
              case (op)
                OP_FETCH, OP_RD_DATA: begin sh <= data_q;   st <= PS_READ; end
                OP_RD_CFG:            begin sh <= cfg_word; st <= PS_READ; end
                OP_RD_GAIN:           begin sh <= gain_q;   st <= PS_READ; end
                OP_RD_OFS:            begin sh <= ofs_q;    st <= PS_READ; end
                OP_WR_CFG:            begin wsel <= WS_CFG;  st <= PS_WRITE; end
                OP_WR_GAIN:           begin wsel <= WS_GAIN; st <= PS_WRITE; end
                OP_WR_OFS:            begin wsel <= WS_OFS;  st <= PS_WRITE; end
                default:              st <= PS_CMD;
              endcase
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        PS_WRITE: begin
          if (sclk_rise) begin
            sh <= wr_word;
            if (bitcnt == DAT_END) begin
              bitcnt <= '0;
              st     <= PS_CMD;
              case (wsel)
                WS_CFG:  pf     <= wr_word[PF_BIT];
                WS_GAIN: gain_q <= wr_word;
                default: ofs_q  <= wr_word;
              endcase
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: begin
          if (sclk_fall) sh <= {sh[DATA_W-2:0], 1'b0};
          if (sclk_rise) begin
            if (bitcnt == DAT_END) begin
              bitcnt <= '0;
              st     <= PS_CMD;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // output pin: shift data in read mode, flag level otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (st == PS_READ) begin
      if (sclk_fall) sdo_q <= sh[DATA_W-1];
    end else begin
      sdo_q <= pf & ~flag_pend;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk
  import adc_port_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input port_st_t st,
  input logic     pf,
  input logic     df,
  input logic     flag_pend,
  input logic     sdo,
  input logic     sclk_fall,
  input logic     eng_done,
  input logic     rd_clr,
  input logic     start_single,
  input logic     start_cont
);
  AST_DF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(eng_done && !pf)) |=> !df); // R4

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && pf) |=> flag_pend); // R6

  AST_NO_DF_IN_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf && !df) |=> !df); // R6

  AST_READ_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_READ && !sclk_fall) |=> $stable(sdo)); // R9

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_single, start_cont})); // R5

  AST_IDLE_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_CMD && $past(st) == PS_CMD && pf && $past(pf)
     && !flag_pend && !$past(flag_pend)) |-> sdo); // R6
endmodule

bind adc_cmd_port adc_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .pf(pf), .df(df),
  .flag_pend(flag_pend), .sdo(sdo), .sclk_fall(sclk_fall),
  .eng_done(eng_done), .rd_clr(rd_clr),
  .start_single(start_single), .start_cont(start_cont)
);

// File: tb/adc_cmd_port_bench.sv
module adc_cmd_port_bench;
  localparam int CONV = 1000;
  localparam int HP   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [23:0] sample_in = '0;
  logic        sdo;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural model of the host-visible state
  bit          m_pf = 0, m_df = 0;
  logic [23:0] m_gain = 24'h400000, m_ofs = 24'h0;

  // pulse-width monitor state
  bit mon_arm = 0, mon_got = 0;
  int hi_cnt = 0, mon_w = 0;

  always #5 clk = ~clk;

  adc_cmd_port #(.CONV_CYCLES(CONV)) u_adc_cmd_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
    .sample_in(sample_in), .sdo(sdo)
  );

  always @(negedge clk) begin
    if (mon_arm) begin
      if (sdo === 1'b1) hi_cnt++;
      else if (hi_cnt > 0) begin
        mon_w   = hi_cnt;
        mon_got = 1;
        mon_arm = 0;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic o);
    sdi = b;
    o = sdo;
    sclk = 1'b1;
    idle(HP);
    sclk = 1'b0;
    idle(HP);
  endtask

  task automatic send_byte(input logic [7:0] c);
    logic o;
    for (int i = 7; i >= 0; i--) bit_cycle(c[i], o);
    sdi = 1'b0;
  endtask

  task automatic shift24(input logic [23:0] din, output logic [23:0] dout);
    logic o;
    for (int i = 23; i >= 0; i--) begin
      bit_cycle(din[i], o);
      dout[i] = o;
    end
    sdi = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] c, output logic [23:0] v);
    send_byte(c);
    shift24(24'h0, v);
  endtask

  task automatic write_reg(input logic [7:0] c, input logic [23:0] v);
    logic [23:0] dummy;
    send_byte(c);
    shift24(v, dummy);
  endtask

  task automatic wait_low(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sdo === 1'b0) begin seen = 1; break; end
    end
  endtask

  function automatic logic [23:0] exp_cfg();
    return {20'h0, m_df, 2'b00, m_pf};
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] v;
    bit seen;
    idle(5);
    rst_n = 1'b1;
    idle(10);

    // reset state
    check("R1", "sdo after reset", sdo, 1'b0);
    read_reg(8'h92, v); check("R1", "cfg reset", v, 24'h0);
    read_reg(8'h93, v); check("R1", "gain reset", v, 24'h400000);
    read_reg(8'h91, v); check("R1", "offset reset", v, 24'h0);

    // register writes
    m_gain = 24'h123456; m_ofs = 24'hABCDEF;
    write_reg(8'h83, m_gain);
    write_reg(8'h81, m_ofs);
    read_reg(8'h93, v); check("R2", "gain write/read", v, m_gain);
    read_reg(8'h91, v); check("R2", "offset write/read", v, m_ofs);
    write_reg(8'h82, 24'hFFFFF6);
    read_reg(8'h92, v); check("R2", "cfg write touches bit0 only", v, 24'h0);

    // unrecognised byte
    send_byte(8'h55);
    read_reg(8'h93, v); check("R12", "command after unknown byte", v, m_gain);

    // single conversion, done-bit mode
    sample_in = 24'h5A5A01;
    send_byte(8'hC0);
    read_reg(8'h92, v); check("R3", "done bit before completion", v, exp_cfg());
    idle(CONV + 200);
    m_df = 1;
    read_reg(8'h92, v); check("R3", "done bit after completion", v, exp_cfg());
    read_reg(8'h92, v); check("R4", "cfg read keeps done bit", v, exp_cfg());
    read_reg(8'h96, v); check("R3", "conversion data", v, 24'h5A5A01);
    m_df = 0;
    read_reg(8'h92, v); check("R4", "data read clears done bit", v, exp_cfg());

    send_byte(8'hC0); idle(CONV + 200);
    read_reg(8'h93, v);
    read_reg(8'h92, v); check("R4", "gain read clears done bit", v, exp_cfg());
    send_byte(8'hC0); idle(CONV + 200);
    read_reg(8'h91, v);
    read_reg(8'h92, v); check("R4", "offset read clears done bit", v, exp_cfg());

    // restart by a second single command
    sample_in = 24'h111111;
    send_byte(8'hC0); idle(500);
    send_byte(8'hC0); idle(400);
    read_reg(8'h92, v); check("R5", "abandoned conversion not done", v, exp_cfg());
    idle(1000);
    m_df = 1;
    read_reg(8'h92, v); check("R5", "restarted conversion done", v, exp_cfg());
    read_reg(8'h96, v); check("R5", "restarted conversion data", v, 24'h111111);
    m_df = 0;

    // flag mode
    m_pf = 1;
    write_reg(8'h82, 24'h000001);
    idle(4);
    check("R6", "sdo idles high", sdo, 1'b1);
    sample_in = 24'h9C3E71;
    send_byte(8'hC0); idle(200);
    check("R6", "sdo high while converting", sdo, 1'b1);
    wait_low(CONV + 200, seen);
    check("R6", "sdo falls on completion", seen, 1'b1);
    send_byte(8'h96); idle(4);
    check("R8", "explicit data read ignored", sdo, 1'b0);
    send_byte(8'h00);
    shift24(24'h0, v);
    check("R7", "fetched result", v, 24'h9C3E71);
    idle(4);
    check("R7", "sdo high after fetch", sdo, 1'b1);

    // sdi ignored during readout
    sample_in = 24'h0F0F0F;
    send_byte(8'hC0);
    wait_low(CONV + 200, seen);
    send_byte(8'h00);
    shift24(24'hC0C0C0, v);
    check("R9", "result with busy sdi", v, 24'h0F0F0F);
    wait_low(CONV + 500, seen);
    check("R9", "no conversion from readout bits", seen, 1'b0);

    // continuous mode, dropped result and one-clock gap
    sample_in = 24'h000AAA;
    send_byte(8'hA0);
    wait_low(CONV + 200, seen);
    check("R10", "first continuous result", seen, 1'b1);
    sample_in = 24'h000BBB;
    hi_cnt = 0; mon_got = 0; mon_arm = 1;
    for (int i = 0; i < CONV + 200 && !mon_got; i++) idle(1);
    mon_arm = 0;
    check("R10", "gap width in clocks", mon_w, 1);
    sample_in = 24'h000CCC;
    send_byte(8'h00);
    shift24(24'h0, v);
    check("R10", "unread result replaced", v, 24'h000BBB);

    // leave continuous mode with a gain read
    read_reg(8'h93, v); check("R11", "gain read in continuous", v, m_gain);
    wait_low(CONV + 200, seen);
    check("R11", "current conversion completes", seen, 1'b1);
    send_byte(8'h00);
    shift24(24'h0, v);
    check("R11", "last result", v, 24'h000CCC);
    wait_low(2 * CONV + 500, seen);
    check("R11", "no further conversions", seen, 1'b0);

    // back to done-bit mode
    m_pf = 0;
    write_reg(8'h82, 24'h000000);
    read_reg(8'h92, v); check("R6", "done bit not set in flag mode", v, exp_cfg());
    idle(4);
    check("R1", "sdo low in done-bit mode", sdo, 1'b0);

    sample_in = 24'h777001;
    send_byte(8'hA0);
    idle(2 * CONV + 300);
    m_df = 1;
    read_reg(8'h92, v); check("R10", "continuous sets done bit", v, exp_cfg());
    read_reg(8'h96, v); check("R10", "continuous data", v, 24'h777001);

    finish_run();
  end
endmodule